// File: doc/BRIEF.md
# SD Card Clock Divider

The block derives the SD card clock from the host clock. A single control register, written as one 32-bit word, holds an output-enable bit, an auto-stop bit and an irregularly encoded power-of-two divider field. The ratio runs from 1 (the host clock passed straight through) up to 512. A build parameter adds a divide-by-1024 setting. The block drives the card-clock level and a one-host-cycle strobe that marks each rising edge of the card clock, so that logic in the host domain can act in step with the card.

To change the rate, software clears the enable bit, rewrites the divider and then sets the enable bit again. The block guarantees the card never sees a shortened pulse. A high phase always runs to completion. After enable, the clock starts only when a full low phase has elapsed. With auto-stop set, the clock parks low at the end of a low phase whenever the bus-busy input is low, and it resumes with a full high phase as soon as the bus is busy again.

The sequencer has five states. `ST_OFF` holds the output low with the counter at zero. `ST_LOW` and `ST_HIGH` are the two halves of a divided period. `ST_PARK` is the auto-stop hold. `ST_PASS` is the divide-by-1 pass-through. The transitions are:

- **enable:** `ST_OFF`→`ST_LOW`.
- **low phase end:** `ST_LOW`→`ST_HIGH`; or `ST_LOW`→`ST_PARK` when idle with auto-stop; or `ST_LOW`→`ST_PASS` when /1 is selected.
- **high phase end:** `ST_HIGH`→`ST_LOW`, or `ST_HIGH`→`ST_OFF` when disabled.
- **disable:** `ST_LOW`/`ST_PARK`/`ST_PASS`→`ST_OFF`.
- **resume:** `ST_PARK`→`ST_HIGH` or `ST_PARK`→`ST_PASS`.
- **auto-stop from pass-through:** `ST_PASS`→`ST_PARK`.
- **leave /1:** `ST_PASS`→`ST_LOW`.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the control register is zero, and both `card_clk` and `card_clk_stb` are low.
- R2: With every divider bit clear (bits 7..0, 10 and 16 all zero), the card clock period is 2 host cycles.
- R3: Divider bit k (k = 0..7, one-hot) selects a period of 4·2^k host cycles (bit 0 = /4 … bit 7 = /512).
- R4: Bit 16 selects /1024 when the parameter HAS_DIV1024 is 1. When HAS_DIV1024 is 0, bit 16 has no effect: with bit 16 alone set, the period is 2.
- R5: Bit 10 alone selects /1. In that mode the card clock is the host clock itself, and the strobe is high on every host cycle.
- R6: When several divider bits are set, the largest division among them is used; bit 10 is used only when no other divider bit is set.
- R7: For every ratio N ≥ 2, the card clock is high for N/2 host cycles and low for N/2 host cycles, and the strobe pulses once per period, in the first high cycle.
- R8: Bit 8 enables the output. When it is cleared, the current high phase completes, the output then stays low, and the phase counter is zero. After it is set again, a full low phase passes before the first high phase.
- R9: With bit 9 set and `bus_busy` low, the clock is held low from the end of a low phase onward. When `bus_busy` goes high, it resumes with a full high phase.
- R10: With bit 9 clear, `bus_busy` has no effect on the card clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 32 | Control word: [7:0] /512../4, [8] enable, [9] auto-stop, [10] /1, [16] /1024 |
| bus_busy | input | 1 | High while the card bus carries a command or data |
| card_clk_stb | output | 1 | One host cycle per card-clock rising edge |
| card_clk | output | 1 | Card clock level |

## Verification
The in-RTL assertions check five rules on every cycle:
- a high or low phase is never left before it has lasted N/2 cycles;
- a disabled sequencer reaches the off state;
- the phase counter is zero while off;
- a parked clock stays parked while the bus is idle with auto-stop set;
- in pass-through the strobe follows the gated host clock.

Only the bench scenarios can show the decoded ratio for each divider bit, the priority rule, the ignored /1024 bit on a build without it, the 50% duty, and the restart delay after re-enable. The bench shows these by comparing both outputs against a behavioural model on every clock and by measuring periods directly.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    localparam int CTL_W       = 32;
    localparam int DIV_LO_N    = 8;
    localparam int EN_BIT      = 8;
    localparam int AUTO_BIT    = 9;
    localparam int BYPASS_BIT  = 10;
    localparam int DIV1024_BIT = 16;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_LOW,
        ST_HIGH,
        ST_PARK,
        ST_PASS
    } clk_state_e;

    typedef struct packed {
        logic                div1024;
        logic                bypass;
        logic                auto_stop;
        logic                en;
        logic [DIV_LO_N-1:0] div_lo;
    } ctl_t;

endpackage

// File: rtl/sdclk_ctl_reg.sv
module sdclk_ctl_reg
    import sdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl
);

    ctl_t ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr) begin
            ctl_q.div_lo    <= wdata[DIV_LO_N-1:0];
            ctl_q.en        <= wdata[EN_BIT];
            ctl_q.auto_stop <= wdata[AUTO_BIT];
            ctl_q.bypass    <= wdata[BYPASS_BIT];
            ctl_q.div1024   <= wdata[DIV1024_BIT];
        end
    end

    assign ctl = ctl_q;

    // R1: the register is empty in the first cycle after reset
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n)) |-> (ctl_q == '0));

endmodule

// File: rtl/sdclk_div_decode.sv
module sdclk_div_decode
    import sdclk_pkg::*;
#(
    parameter bit HAS_DIV1024 = 1'b1,
    parameter int MAX_LOG     = 10,
    parameter int CNT_W       = MAX_LOG,
    localparam int LOG_W      = $clog2(MAX_LOG + 1)
) (
    input  ctl_t             ctl,
    output logic [LOG_W-1:0] div_log,
    output logic [CNT_W-1:0] half,
    output logic             bypass_sel
);

    logic [LOG_W-1:0] lo_log;
    logic             top_sel;

    // lowest priority: /1 or default /2; higher set bits overwrite
    always_comb begin
        lo_log = ctl.bypass ? LOG_W'(0) : LOG_W'(1);
        for (int k = 0; k < DIV_LO_N; k++) begin
            if (ctl.div_lo[k]) begin
                lo_log = LOG_W'(k + 2);
            end
        end
    end

    generate
        if (HAS_DIV1024) begin : g_cap1024
            assign top_sel = ctl.div1024;
        end else begin : g_nocap
            assign top_sel = 1'b0;
        end
    endgenerate

    always_comb begin
        div_log = top_sel ? LOG_W'(MAX_LOG) : lo_log;
        if (div_log == '0) begin
            half = CNT_W'(1);
        end else begin
            half = CNT_W'(1) << (div_log - LOG_W'(1));
        end
        bypass_sel = (div_log == '0);
    end

endmodule

// File: rtl/sdclk_fsm.sv
module sdclk_fsm
    import sdclk_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             auto_stop,
    input  logic             bus_busy,
    input  logic             bypass_sel,
    input  logic [CNT_W-1:0] half,
    output logic             card_clk_stb,
    output logic             card_clk
);

    clk_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             gate_q;
    logic             phase_end;
    logic             idle_stop;

    assign phase_end = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, half};
    assign idle_stop = auto_stop & ~bus_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            ST_OFF: begin
                if (en) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (!en) begin
                    state_d = ST_OFF;
                end else if (!phase_end) begin
                    cnt_d = cnt_q + CNT_W'(1);
                end else if (idle_stop) begin
                    state_d = ST_PARK;
                end else if (bypass_sel) begin
                    state_d = ST_PASS;
                end else begin
                    state_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (!phase_end) begin
                    cnt_d = cnt_q + CNT_W'(1);
                end else if (!en) begin
                    state_d = ST_OFF;
                end else begin
                    state_d = ST_LOW;
                end
            end
            ST_PARK: begin
                if (!en) begin
                    state_d = ST_OFF;
                end else if (!idle_stop) begin
                    state_d = bypass_sel ? ST_PASS : ST_HIGH;
                end
            end
            ST_PASS: begin
                if (!en) begin
                    state_d = ST_OFF;
                end else if (idle_stop) begin
                    state_d = ST_PARK;
                end else if (!bypass_sel) begin
                    state_d = ST_LOW;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // pass-through gate changes only while the host clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= (state_q == ST_PASS);
        end
    end

    always_comb begin
        card_clk     = (state_q == ST_HIGH) | (clk & gate_q);
        card_clk_stb = ((state_q == ST_HIGH) && (cnt_q == '0)) ||
                       ((state_q == ST_PASS) && gate_q);
    end

    // R7: a high phase is left only after half cycles
    assert_full_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_HIGH && state_q != ST_HIGH) |->
        (({1'b0, $past(cnt_q)} + (CNT_W+1)'(1)) >= {1'b0, $past(half)}));

    // R8: restart into high only after a full low phase
    assert_full_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_LOW && state_q == ST_HIGH) |->
        (({1'b0, $past(cnt_q)} + (CNT_W+1)'(1)) >= {1'b0, $past(half)}));

    // R8: disabled outside a high phase means off next cycle
    assert_off_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!en) && $past(state_q) != ST_HIGH) |-> (state_q == ST_OFF));

    // R8: counter is cleared while off
    assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (cnt_q == '0));

    // R9: parked clock stays parked while idle with auto-stop
    assert_park_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_PARK && $past(en) && $past(idle_stop)) |->
        (state_q == ST_PARK));

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter bit HAS_DIV1024 = 1'b1,
    localparam int MAX_LOG    = HAS_DIV1024 ? 10 : 9,
    localparam int CNT_W      = MAX_LOG,
    localparam int LOG_W      = $clog2(MAX_LOG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CTL_W-1:0] cfg_wdata,
    input  logic             bus_busy,
    output logic             card_clk_stb,
    output logic             card_clk
);

    ctl_t             ctl;
    logic [LOG_W-1:0] div_log;
    logic [CNT_W-1:0] half;
    logic             bypass_sel;

    sdclk_ctl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .ctl   (ctl)
    );

    sdclk_div_decode #(
        .HAS_DIV1024 (HAS_DIV1024),
        .MAX_LOG     (MAX_LOG),
        .CNT_W       (CNT_W)
    ) u_dec (
        .ctl        (ctl),
        .div_log    (div_log),
        .half       (half),
        .bypass_sel (bypass_sel)
    );

    sdclk_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (ctl.en),
        .auto_stop    (ctl.auto_stop),
        .bus_busy     (bus_busy),
        .bypass_sel   (bypass_sel),
        .half         (half),
        .card_clk_stb (card_clk_stb),
        .card_clk     (card_clk)
    );

    // R5: in pass-through the strobe follows the gated host clock
    assert_pass_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bypass_sel) && bypass_sel && $past(card_clk_stb)) |-> card_clk_stb ||
        $past(!ctl.en) || $past(ctl.auto_stop) || $past(div_log) != div_log);

endmodule

// File: tb/sim_sdclk_gen.sv
module sim_sdclk_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [31:0] cfg_wdata;
    logic        bus_busy;
    logic        stb0, cko0, stb1, cko1;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    sdclk_gen #(.HAS_DIV1024(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .bus_busy(bus_busy), .card_clk_stb(stb0), .card_clk(cko0));

    sdclk_gen #(.HAS_DIV1024(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .bus_busy(bus_busy), .card_clk_stb(stb1), .card_clk(cko1));

    // behavioural reference: 0 off, 1 low, 2 high, 3 park, 4 pass
    int          m_st, m_cnt;
    logic [31:0] m_reg;
    bit          m_gate;

    function automatic int ref_div(logic [31:0] r, bit cap);
        if (cap && r[16]) return 1024;
        for (int k = 7; k >= 0; k--) if (r[k]) return 4 << k;
        if (r[10]) return 1;
        return 2;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0; m_reg <= '0;
        end else begin
            int d, h, ns, nc;
            bit en, idl, pe;
            d   = ref_div(m_reg, 1'b1);
            h   = (d == 1) ? 1 : d / 2;
            en  = m_reg[8];
            idl = m_reg[9] && !bus_busy;
            pe  = (m_cnt + 1 >= h);
            ns  = m_st; nc = 0;
            case (m_st)
                0: if (en) ns = 1;
                1: if (!en) ns = 0; else if (!pe) nc = m_cnt + 1;
                   else if (idl) ns = 3; else if (d == 1) ns = 4; else ns = 2;
                2: if (!pe) nc = m_cnt + 1; else if (!en) ns = 0; else ns = 1;
                3: if (!en) ns = 0; else if (!idl) ns = (d == 1) ? 4 : 2;
                4: if (!en) ns = 0; else if (idl) ns = 3; else if (d != 1) ns = 1;
                default: ns = 0;
            endcase
            m_st <= ns; m_cnt <= nc;
            if (cfg_wr) m_reg <= cfg_wdata;
        end
    end

    always @(negedge clk or negedge rst_n) begin
        if (!rst_n) m_gate <= 1'b0;
        else        m_gate <= (m_st == 4);
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(posedge clk) begin
        #1.25;
        if (rst_n && !done) begin
            chk(cko0 == ((m_st == 2) || m_gate), cur_req, "card_clk vs model",
                int'(cko0), int'((m_st == 2) || m_gate));
            chk(stb0 == (((m_st == 2) && m_cnt == 0) || ((m_st == 4) && m_gate)),
                cur_req, "stb vs model", int'(stb0),
                int'(((m_st == 2) && m_cnt == 0) || ((m_st == 4) && m_gate)));
        end
    end

    task automatic sample();
        @(posedge clk); #1.25;
    endtask

    task automatic write_ctl(logic [31:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    function automatic bit pick(bit which);
        return which ? stb1 : stb0;
    endfunction

    task automatic measure(bit which, int exp, string req);
        int n;
        for (int rep = 0; rep < 2; rep++) begin
            do sample(); while (!pick(which));
            n = 0;
            do begin sample(); n++; end while (!pick(which));
        end
        chk(n == exp, req, "period", n, exp);
    endtask

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; bus_busy = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sample();
        chk(cko0 == 1'b0, "R1", "card_clk after reset", int'(cko0), 0);
        chk(stb0 == 1'b0, "R1", "stb after reset", int'(stb0), 0);

        cur_req = "R2";
        write_ctl(32'h100);
        measure(1'b0, 2, "R2");

        cur_req = "R3";
        for (int k = 0; k < 8; k++) begin
            write_ctl(32'h100 | (32'h1 << k));
            measure(1'b0, 4 << k, "R3");
        end

        cur_req = "R4";
        write_ctl(32'h100 | 32'h1_0000);
        measure(1'b0, 1024, "R4");
        measure(1'b1, 2, "R4");

        cur_req = "R5";
        write_ctl(32'h100 | 32'h400);
        measure(1'b0, 1, "R5");
        sample();
        chk(cko0 == 1'b1, "R5", "pass-through high", int'(cko0), 1);

        cur_req = "R6";
        write_ctl(32'h100 | 32'h400 | 32'h8 | 32'h2);
        measure(1'b0, 32, "R6");

        cur_req = "R7";
        write_ctl(32'h100 | 32'h4);
        measure(1'b0, 16, "R7");
        begin
            int hi;
            do sample(); while (!stb0);
            hi = int'(cko0);
            for (int i = 1; i < 16; i++) begin sample(); hi += int'(cko0); end
            chk(hi == 8, "R7", "high cycles per period", hi, 8);
        end

        cur_req = "R8";
        write_ctl(32'h100 | 32'h2);
        measure(1'b0, 8, "R8");
        write_ctl(32'h2);
        repeat (6) sample();
        begin
            int hi = 0;
            for (int i = 0; i < 20; i++) begin sample(); hi += int'(cko0) + int'(stb0); end
            chk(hi == 0, "R8", "activity while disabled", hi, 0);
        end
        write_ctl(32'h100 | 32'h2);
        measure(1'b0, 8, "R8");

        cur_req = "R9";
        bus_busy = 1'b0;
        write_ctl(32'h300 | 32'h1);
        repeat (8) sample();
        begin
            int hi = 0;
            for (int i = 0; i < 12; i++) begin sample(); hi += int'(cko0) + int'(stb0); end
            chk(hi == 0, "R9", "activity while parked", hi, 0);
        end
        bus_busy = 1'b1;
        measure(1'b0, 4, "R9");

        cur_req = "R10";
        write_ctl(32'h100 | 32'h1);
        bus_busy = 1'b0;
        measure(1'b0, 4, "R10");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(190000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule